// File: doc/BRIEF.md
# Two-Dimensional Life Lattice Core

This block holds a rectangular lattice of single-bit cells, `ROWS` by `COLS`, and advances every cell at once under the Game of Life rule. Each cell looks at its eight surrounding cells. A build-time parameter chooses what lies beyond the edges. In the periodic variant the lattice wraps onto itself, so it behaves as a torus. In the null variant every cell outside the lattice counts as dead.

The lattice has three uses. It can be filled one row at a time from the top. It can be scanned out one row at a time from the bottom. It can be iterated, and one whole generation takes one clock cycle. Loading and reading both turn the lattice into a row-wide shift register that moves downward. On a read, the bottom row wraps back to the top, so reading all rows leaves the contents exactly as they were. A small controller counts generations. It can run straight through to a requested count, or it can pause after every generation until it is told to continue.

Top module: `ca_lattice_core`

## Requirements
- R1: After a synchronous reset, every cell is 0, `iter_count` is 0, and `busy`, `done` and `waiting` are all low.
- R2: When the core is idle and `cmd_load` is high, every row moves down by one. `row_in` bit j enters column j of the top row, and the old bottom row is dropped. `row_out` always shows the bottom row, with bit j taken from column j.
- R3: When the core is idle, `cmd_read` is high and `cmd_load` is low, every row moves down by one and the old bottom row becomes the top row. `ROWS` reads in a row restore the lattice. If load and read are both high, load wins.
- R4: One generation applies this rule. A live cell with 2 or 3 live neighbours stays alive. A dead cell with exactly 3 live neighbours becomes alive. Every other cell is dead afterwards.
- R5: With `PERIODIC`=1, neighbours wrap across opposite edges. With `PERIODIC`=0, positions outside the lattice count as dead.
- R6: While running, each clock cycle applies exactly one generation and raises `iter_count` by one.
- R7: In an idle cycle, `cmd_start` latches `n_iter` and clears `iter_count`. The core then runs until `iter_count` equals that value. It then raises `done`, drops `busy` and freezes the lattice until `cmd_stop`.
- R8: If `step_mode` was high at start, the core raises `waiting` after each generation that does not reach the count. The lattice holds until `cmd_continue`, and the core still finishes at the count.
- R9: `cmd_stop` while running, paused or done returns the core to idle within one cycle, and no generation is applied in that cycle.
- R10: A start with `n_iter`=0 goes straight to `done` without applying any generation.
- R11: `cmd_load` and `cmd_read` have no effect unless the core is idle. In an idle cycle either of them takes priority over `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Shift the lattice down and insert `row_in` at the top |
| cmd_read | input | 1 | Rotate the lattice down by one row |
| cmd_start | input | 1 | Begin an iteration run |
| step_mode | input | 1 | Sampled at start: pause after each generation |
| cmd_continue | input | 1 | Resume from a pause |
| cmd_stop | input | 1 | Abort or acknowledge and return to idle |
| n_iter | input | CNT_W | Number of generations to run |
| row_in | input | COLS | Row written into the top row on a load |
| row_out | output | COLS | Current bottom row |
| busy | output | 1 | Running or paused |
| done | output | 1 | Requested count reached |
| waiting | output | 1 | Paused in step mode |
| iter_count | output | CNT_W | Generations applied in the current run |

## Verification
A wrong rule term or a wrong neighbour index in any cell stays hidden until that row reaches the bottom. It appears on `row_out` during a full read sweep, at the latest `ROWS` cycles after the run ends. Because of that, every run in the bench is followed by a sweep. A wrong controller state shows up on `busy`, `done`, `waiting` or `iter_count` in the very next cycle. A wrong edge choice affects only patterns that touch the boundary, so a periodic and a null instance run the same edge pattern side by side.

// File: rtl/ca_lattice_pkg.sv
package ca_lattice_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD, ST_DONE} ca_state_e;

  // Life transition: birth on 3, survival on 2 or 3
  function automatic logic life_next(input logic self, input logic [7:0] nb);
    int unsigned live;
    live = 0;
    for (int i = 0; i < 8; i++) live += int'(nb[i]);
    return (live == 3) || (self && live == 2);
  endfunction

endpackage

// File: rtl/ca_cell.sv
module ca_cell
  import ca_lattice_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rule_en,
  input  logic       north_en,
  input  logic       north_bit,
  input  logic [7:0] nb,
  output logic       q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (rule_en)  q <= life_next(q, nb);
    else if (north_en) q <= north_bit;
  end
endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_lattice_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_load,
  input  logic             cmd_read,
  input  logic             cmd_start,
  input  logic             step_mode,
  input  logic             cmd_continue,
  input  logic             cmd_stop,
  input  logic [CNT_W-1:0] n_iter,
  output logic             iter_en,
  output logic             shift_en,
  output logic             load_sel,
  output logic             busy,
  output logic             done,
  output logic             waiting,
  output logic [CNT_W-1:0] iter_count
);
  ca_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, target_q;
  logic             step_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      target_q <= '0;
      step_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (!cmd_load && !cmd_read && cmd_start) begin
          target_q <= n_iter;
          step_q   <= step_mode;
          cnt_q    <= '0;
          state_q  <= (n_iter == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (cmd_stop) state_q <= ST_IDLE;
          else begin
            cnt_q <= cnt_inc;
            if (cnt_inc == target_q) state_q <= ST_DONE;
            else if (step_q)         state_q <= ST_HOLD;
          end
        ST_HOLD: if (cmd_stop) state_q <= ST_IDLE;
          else if (cmd_continue) state_q <= ST_RUN;
        default: if (cmd_stop) state_q <= ST_IDLE;
      endcase
    end
  end

  assign iter_en    = (state_q == ST_RUN) && !cmd_stop;
  assign shift_en   = (state_q == ST_IDLE) && (cmd_load || cmd_read);
  assign load_sel   = cmd_load;
  assign busy       = (state_q == ST_RUN) || (state_q == ST_HOLD);
  assign done       = (state_q == ST_DONE);
  assign waiting    = (state_q == ST_HOLD);
  assign iter_count = cnt_q;
endmodule

// File: rtl/ca_lattice.sv
module ca_lattice #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter bit PERIODIC = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iter_en,
  input  logic                 shift_en,
  input  logic                 load_sel,
  input  logic [COLS-1:0]      row_in,
  output logic [ROWS*COLS-1:0] grid
);
  localparam int CELLS = ROWS * COLS;
  localparam int BOT   = (ROWS - 1) * COLS;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [7:0] nb;
      logic       north;

      for (genvar j = 0; j < 8; j++) begin : g_nb
        localparam int K  = (j < 4) ? j : j + 1;
        localparam int RR = r + K / 3 - 1;
        localparam int CC = c + K % 3 - 1;
        localparam bit INSIDE = (RR >= 0) && (RR < ROWS) && (CC >= 0) && (CC < COLS);
        localparam int RW = (RR + ROWS) % ROWS;
        localparam int CW = (CC + COLS) % COLS;
        if (PERIODIC || INSIDE) begin : g_live
          assign nb[j] = grid[RW*COLS + CW];
        end else begin : g_zero
          assign nb[j] = 1'b0;
        end
      end

      if (r == 0) begin : g_top
        assign north = load_sel ? row_in[c] : grid[BOT + c];
      end else begin : g_inner
        assign north = grid[(r-1)*COLS + c];
      end

      ca_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .rule_en   (iter_en),
        .north_en  (shift_en),
        .north_bit (north),
        .nb        (nb),
        .q         (grid[r*COLS + c])
      );
    end
  end

  if (CELLS < 9) begin : g_size_guard
    initial $display("ca_lattice: small lattice, neighbours may alias");
  end
endmodule

// File: rtl/ca_lattice_core.sv
module ca_lattice_core #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int CNT_W    = 16,
  parameter bit PERIODIC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_load,
  input  logic             cmd_read,
  input  logic             cmd_start,
  input  logic             step_mode,
  input  logic             cmd_continue,
  input  logic             cmd_stop,
  input  logic [CNT_W-1:0] n_iter,
  input  logic [COLS-1:0]  row_in,
  output logic [COLS-1:0]  row_out,
  output logic             busy,
  output logic             done,
  output logic             waiting,
  output logic [CNT_W-1:0] iter_count
);
  localparam int BOT = (ROWS - 1) * COLS;

  logic                 iter_en, shift_en, load_sel;
  logic [ROWS*COLS-1:0] grid;

  ca_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_load     (cmd_load),
    .cmd_read     (cmd_read),
    .cmd_start    (cmd_start),
    .step_mode    (step_mode),
    .cmd_continue (cmd_continue),
    .cmd_stop     (cmd_stop),
    .n_iter       (n_iter),
    .iter_en      (iter_en),
    .shift_en     (shift_en),
    .load_sel     (load_sel),
    .busy         (busy),
    .done         (done),
    .waiting      (waiting),
    .iter_count   (iter_count)
  );

  ca_lattice #(.ROWS(ROWS), .COLS(COLS), .PERIODIC(PERIODIC)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .iter_en  (iter_en),
    .shift_en (shift_en),
    .load_sel (load_sel),
    .row_in   (row_in),
    .grid     (grid)
  );

  assign row_out = grid[BOT +: COLS];
endmodule

// File: rtl/ca_lattice_core_chk.sv
module ca_lattice_core_chk #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_load,
  input logic                 cmd_read,
  input logic                 cmd_continue,
  input logic                 cmd_stop,
  input logic [COLS-1:0]      row_in,
  input logic [COLS-1:0]      row_out,
  input logic                 busy,
  input logic                 done,
  input logic                 waiting,
  input logic [CNT_W-1:0]     iter_count,
  input logic [ROWS*COLS-1:0] grid
);
  logic idle;
  assign idle = !busy && !done;

  // R2
  load_top_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_load) |=> (grid[COLS-1:0] == $past(row_in)));

  // R3
  read_rot_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_read && !cmd_load) |=> (grid[COLS-1:0] == $past(row_out)));

  // R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(idle && (cmd_load || cmd_read))) |=> $stable(grid));

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !cmd_continue && !cmd_stop) |=> (waiting && $stable(grid)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_stop) |=> done);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((busy || done) && cmd_stop) |=> (!busy && !done));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !waiting && !cmd_stop) |=> (iter_count == $past(iter_count) + 1'b1));
endmodule

bind ca_lattice_core ca_lattice_core_chk #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_load     (cmd_load),
  .cmd_read     (cmd_read),
  .cmd_continue (cmd_continue),
  .cmd_stop     (cmd_stop),
  .row_in       (row_in),
  .row_out      (row_out),
  .busy         (busy),
  .done         (done),
  .waiting      (waiting),
  .iter_count   (iter_count),
  .grid         (grid)
);

// File: tb/ca_lattice_core_test.sv
module ca_lattice_core_test;
  localparam int ROWS = 6;
  localparam int COLS = 8;
  localparam int CW   = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_load = 0, cmd_read = 0, cmd_start = 0, step_mode = 0, cmd_continue = 0, cmd_stop = 0;
  logic [CW-1:0]   n_iter = '0;
  logic [COLS-1:0] row_in = '0;

  logic [COLS-1:0] ro_p, ro_n;
  logic busy_p, done_p, wait_p, busy_n, done_n, wait_n;
  logic [CW-1:0] cnt_p, cnt_n;

  int checks = 0, errors = 0;
  string req = "R1";
  bit cmp_on = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ca_lattice_core #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CW), .PERIODIC(1'b1)) uut (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_read(cmd_read), .cmd_start(cmd_start),
    .step_mode(step_mode), .cmd_continue(cmd_continue), .cmd_stop(cmd_stop), .n_iter(n_iter),
    .row_in(row_in), .row_out(ro_p), .busy(busy_p), .done(done_p), .waiting(wait_p),
    .iter_count(cnt_p));

  ca_lattice_core #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CW), .PERIODIC(1'b0)) uut_null (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_read(cmd_read), .cmd_start(cmd_start),
    .step_mode(step_mode), .cmd_continue(cmd_continue), .cmd_stop(cmd_stop), .n_iter(n_iter),
    .row_in(row_in), .row_out(ro_n), .busy(busy_n), .done(done_n), .waiting(wait_n),
    .iter_count(cnt_n));

  // Reference model: index 0 periodic, index 1 null boundary
  bit mg [2][ROWS][COLS];
  int ms = 0, mcnt = 0, mn = 0;
  bit mstep = 0;

  function automatic int live_around(int b, int r, int c);
    int n = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        int rr = r + dr, cc = c + dc;
        if (dr == 0 && dc == 0) continue;
        if (b == 0) n += int'(mg[0][(rr + ROWS) % ROWS][(cc + COLS) % COLS]);
        else if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) n += int'(mg[1][rr][cc]);
      end
    return n;
  endfunction

  task automatic model_life();
    bit nxt [2][ROWS][COLS];
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          int n = live_around(b, r, c);
          nxt[b][r][c] = (n == 3) || (mg[b][r][c] && n == 2);
        end
    mg = nxt;
  endtask

  task automatic model_shift(bit ld, logic [COLS-1:0] v);
    for (int b = 0; b < 2; b++) begin
      bit bot [COLS];
      for (int c = 0; c < COLS; c++) bot[c] = mg[b][ROWS-1][c];
      for (int r = ROWS - 1; r > 0; r--)
        for (int c = 0; c < COLS; c++) mg[b][r][c] = mg[b][r-1][c];
      for (int c = 0; c < COLS; c++) mg[b][0][c] = ld ? v[c] : bot[c];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) mg[b][r][c] = 0;
      ms = 0; mcnt = 0; mn = 0; mstep = 0;
    end else begin
      case (ms)
        0: if (cmd_load) model_shift(1, row_in);
           else if (cmd_read) model_shift(0, row_in);
           else if (cmd_start) begin
             mn = int'(n_iter); mstep = step_mode; mcnt = 0;
             ms = (n_iter == 0) ? 3 : 1;
           end
        1: if (cmd_stop) ms = 0;
           else begin
             model_life(); mcnt++;
             if (mcnt == mn) ms = 3; else if (mstep) ms = 2;
           end
        2: if (cmd_stop) ms = 0; else if (cmd_continue) ms = 1;
        default: if (cmd_stop) ms = 0;
      endcase
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [COLS-1:0] exp_row(int b);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[c] = mg[b][ROWS-1][c];
    return v;
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(req, "row_out periodic", ro_p, exp_row(0));
      chk(req, "row_out null", ro_n, exp_row(1));
      chk(req, "busy", busy_p, (ms == 1 || ms == 2));
      chk(req, "done", done_p, (ms == 3));
      chk(req, "waiting", wait_p, (ms == 2));
      chk(req, "iter_count", cnt_p, mcnt);
      chk(req, "null ctrl match", {busy_n, done_n, wait_n, cnt_n}, {busy_p, done_p, wait_p, cnt_p});
    end
  end

  task automatic load_row(logic [COLS-1:0] v);
    cmd_load = 1; row_in = v; @(negedge clk); cmd_load = 0;
  endtask

  task automatic read_all();
    cmd_read = 1; repeat (ROWS) @(negedge clk); cmd_read = 0;
  endtask

  task automatic start(int n, bit step);
    n_iter = CW'(n); step_mode = step; cmd_start = 1; @(negedge clk); cmd_start = 0;
  endtask

  task automatic wait_done(bit poke_load);
    int guard = 0;
    while (!done_p && guard < 1000) begin
      if (wait_p) begin
        if (poke_load) begin
          // R11: commands while paused must not touch the lattice
          cmd_load = 1; cmd_read = 1; row_in = 8'hFF; @(negedge clk);
          cmd_load = 0; cmd_read = 0;
        end
        @(negedge clk);
        cmd_continue = 1; @(negedge clk); cmd_continue = 0;
      end else @(negedge clk);
      guard++;
    end
  endtask

  task automatic stop();
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "row_out", ro_p, 0);
    chk("R1", "busy/done/waiting", {busy_p, done_p, wait_p}, 0);
    chk("R1", "iter_count", cnt_p, 0);
    cmp_on = 1;
    req = "R1"; read_all();

    req = "R2";
    load_row(8'h00); load_row(8'h04); load_row(8'h02);
    load_row(8'h0E); load_row(8'h00); load_row(8'h00);

    req = "R3";
    read_all();
    cmd_load = 1; cmd_read = 1; row_in = 8'hA5; @(negedge clk);
    cmd_load = 0; cmd_read = 0;
    read_all();

    req = "R4";
    start(4, 0);
    req = "R7";
    wait_done(0);
    chk("R6", "count at finish", cnt_p, 4);
    req = "R11";
    cmd_load = 1; row_in = 8'hFF; @(negedge clk); cmd_load = 0;
    cmd_read = 1; @(negedge clk); cmd_read = 0;
    @(negedge clk);
    req = "R9"; stop();
    req = "R4"; read_all();

    req = "R8";
    start(3, 1);
    wait_done(1);
    @(negedge clk);
    stop(); read_all();

    req = "R10";
    start(0, 0);
    chk("R10", "done immediate", done_p, 1);
    chk("R10", "no generation", cnt_p, 0);
    stop(); read_all();

    req = "R9";
    start(20, 0);
    repeat (3) @(negedge clk);
    stop();
    chk("R9", "idle after stop", {busy_p, done_p}, 0);
    read_all();

    req = "R5";
    load_row(8'h83); load_row(8'h00); load_row(8'h00);
    load_row(8'h00); load_row(8'h01); load_row(8'h81);
    start(2, 0); wait_done(0); stop(); read_all();
    start(3, 0); wait_done(0); stop(); read_all();

    cmp_on = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule